// File: doc/BRIEF.md
# Duty-Cycle Clock-and-Data Line Encoder

This block drives the controller end of a one-wire link on which a free-running clock and a serial data stream travel together. Every link-clock period becomes one pulse on the output. The duty cycle of that pulse carries the data bit: a wide pulse is a logic 1 (mark) and a narrow pulse is a logic 0 (space). The falling edge of each pulse always lands on the period boundary, so the far end can recover a steady clock from those falling edges whatever the data is.

A prescaler supplies `slot_en`. This enable marks each quarter of a link period, so a period spans `SLOTS` enabled cycles. An asynchronous transmitter supplies the bit level on `ser_bit`. The encoder holds each bit for a fixed run of link periods. It takes in a new level only at the end of that run and then raises `bit_strobe` for one cycle, which tells the transmitter to present its next bit. If the transmitter idles at 1, the line carries a continuous wide-pulse wave. At a 7.945 µs link period the default parameters match a link on which each bit spans 16 periods.

Top module: `pwm_link_encoder`

## Requirements
- R1: When the held level is 1, each link period of 4 slots (slot index 0..3) is low in slot 0 and high in slots 1, 2 and 3. This is 75 percent high.
- R2: When the held level is 0, each link period is low in slots 0, 1 and 2 and high in slot 3. This is 25 percent high.
- R3: The output falls only where slot 3 of one period moves into slot 0 of the next. It falls at every such boundary.
- R4: The held level changes only at a bit boundary, which is the end of slot 3 of the 16th period of a bit. The value of `ser_bit` at any other time has no effect on the output.
- R5: Each bit lasts exactly 16 link periods (64 enabled slots). `bit_strobe` is high for exactly one clock, in slot 0 of the first period of each new bit.
- R6: While `ser_bit` stays at 1, the output is an unbroken train of 75 percent pulses.
- R7: While `slot_en` is low, the slot position, the output and the held level do not change, and `bit_strobe` stays low.
- R8: A synchronous active-low reset puts the block in slot 0 of period 0 with the held level at 1. The output is low and `bit_strobe` is low. The first bit after reset is always mark.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_en | input | 1 | Prescaler enable; each high cycle advances one quarter-period slot |
| ser_bit | input | 1 | Serial level from the upstream transmitter (1 = mark) |
| link_out | output | 1 | Combined clock-and-data line, registered |
| bit_strobe | output | 1 | One-clock pulse when a new bit has been taken in |

## Verification
The assertions assume that `slot_en` is the only thing that moves the block forward. They also assume that, outside reset, the slot index runs only from 0 to 3. Given that, the checks are that slot 0 is always low, slot 3 is always high, and the output falls only on entry to slot 0. The checks do not rely on `ser_bit` being steady, because the level is latched only at a bit boundary. The stimulus deliberately toggles `ser_bit` in the middle of bits and freezes `slot_en` for several cycles. It also applies reset in the middle of a bit, to show that none of these breaks the fixed falling-edge reference.

// File: rtl/pwm_enc_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the duty-cycle line encoder.
// Assumes pulse lengths are counted in whole quarter-period slots.
package pwm_enc_pkg;

    typedef enum logic {
        LVL_SPACE = 1'b0,
        LVL_MARK  = 1'b1
    } line_level_e;

    // Number of high slots at the end of a period for a given line level.
    function automatic int high_len(logic lvl, int mark_hi, int space_hi);
        return (lvl == LVL_MARK) ? mark_hi : space_hi;
    endfunction

endpackage

// File: rtl/pwm_slot_ctr.sv
`timescale 1ns/1ps
// Slot counter: tracks the position inside one link period.
// Assumes slot_en is a single-cycle enable from an external prescaler.
// Provides the slot that becomes current after this edge, plus a period-end flag.
module pwm_slot_ctr #(
    parameter int SLOTS = 4,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_en,
    output logic [SLOT_W-1:0] slot_idx,
    output logic [SLOT_W-1:0] next_slot,
    output logic              period_end
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    logic [SLOT_W-1:0] slot_q;

    // Flag the enabled cycle that closes the current period.
    always_comb begin
        period_end = slot_en && (slot_q == LAST_SLOT);
    end

    // Choose the slot for the next cycle: wrap, advance or hold.
    always_comb begin
        if (period_end)
            next_slot = '0;
        else if (slot_en)
            next_slot = slot_q + SLOT_W'(1);
        else
            next_slot = slot_q;
    end

    // Hold the slot position.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_q <= '0;
        else
            slot_q <= next_slot;
    end

    assign slot_idx = slot_q;

endmodule

// File: rtl/pwm_period_ctr.sv
`timescale 1ns/1ps
// Period counter: counts link periods within one serial bit.
// Assumes period_end is high for one cycle at each period boundary.
// Flags the bit boundary and registers a one-clock strobe for the transmitter.
module pwm_period_ctr #(
    parameter int PERIODS_PER_BIT = 16,
    localparam int PER_W = (PERIODS_PER_BIT > 1) ? $clog2(PERIODS_PER_BIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic period_end,
    output logic bit_end,
    output logic bit_strobe
);

    localparam logic [PER_W-1:0] LAST_PER = PER_W'(PERIODS_PER_BIT - 1);

    logic [PER_W-1:0] per_q;
    logic             strobe_q;

    // Bit boundary: closing the last period of the current bit.
    always_comb begin
        bit_end = period_end && (per_q == LAST_PER);
    end

    // Count periods, wrapping at the bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            per_q <= '0;
        else if (bit_end)
            per_q <= '0;
        else if (period_end)
            per_q <= per_q + PER_W'(1);
    end

    // One-clock strobe in the first slot of the new bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            strobe_q <= 1'b0;
        else
            strobe_q <= bit_end;
    end

    assign bit_strobe = strobe_q;

endmodule

// File: rtl/pwm_wave_shaper.sv
`timescale 1ns/1ps
// Wave shaper: latches the serial level at bit boundaries and forms the pulse.
// Assumes next_slot is the slot that will be current after this edge.
// The high part sits at the end of the period, so the fall lands on the boundary.
module pwm_wave_shaper
    import pwm_enc_pkg::*;
#(
    parameter int SLOTS    = 4,
    parameter int MARK_HI  = 3,
    parameter int SPACE_HI = 1,
    localparam int SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_end,
    input  logic              ser_bit,
    input  logic [SLOT_W-1:0] next_slot,
    output logic              level_q,
    output logic              link_out
);

    line_level_e lvl_q;
    line_level_e next_lvl;
    logic        out_d;
    logic        out_q;

    // Take a new level only at a bit boundary.
    always_comb begin
        next_lvl = bit_end ? line_level_e'(ser_bit) : lvl_q;
    end

    // High when the coming slot lies in the tail of the period.
    always_comb begin
        out_d = (int'(next_slot) + high_len(next_lvl, MARK_HI, SPACE_HI)) >= SLOTS;
    end

    // Register level and line so the output is glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= LVL_MARK;
            out_q <= 1'b0;
        end else begin
            lvl_q <= next_lvl;
            out_q <= out_d;
        end
    end

    assign level_q  = lvl_q;
    assign link_out = out_q;

endmodule

// File: rtl/pwm_link_encoder.sv
`timescale 1ns/1ps
// Duty-cycle clock-and-data encoder, top level.
// Assumes slot_en marks quarter-period slots and ser_bit is held by the
// transmitter until bit_strobe asks for the next bit.
module pwm_link_encoder #(
    parameter int SLOTS           = 4,
    parameter int MARK_HI         = 3,
    parameter int SPACE_HI        = 1,
    parameter int PERIODS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_en,
    input  logic ser_bit,
    output logic link_out,
    output logic bit_strobe
);

    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [SLOT_W-1:0] slot_idx;
    logic [SLOT_W-1:0] next_slot;
    logic              period_end;
    logic              bit_end;
    logic              level_q;

    pwm_slot_ctr #(.SLOTS(SLOTS)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_en    (slot_en),
        .slot_idx   (slot_idx),
        .next_slot  (next_slot),
        .period_end (period_end)
    );

    pwm_period_ctr #(.PERIODS_PER_BIT(PERIODS_PER_BIT)) u_period (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_end (period_end),
        .bit_end    (bit_end),
        .bit_strobe (bit_strobe)
    );

    pwm_wave_shaper #(
        .SLOTS    (SLOTS),
        .MARK_HI  (MARK_HI),
        .SPACE_HI (SPACE_HI)
    ) u_shape (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_end   (bit_end),
        .ser_bit   (ser_bit),
        .next_slot (next_slot),
        .level_q   (level_q),
        .link_out  (link_out)
    );

endmodule

// File: rtl/pwm_link_encoder_chk.sv
`timescale 1ns/1ps
// Property checker for the duty-cycle encoder, bound into the top level.
// Assumes 0 < SPACE_HI <= MARK_HI < SLOTS.
module pwm_link_encoder_chk #(
    parameter int SLOTS  = 4,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slot_en,
    input logic              link_out,
    input logic              bit_strobe,
    input logic [SLOT_W-1:0] slot_idx,
    input logic              level_q,
    input logic              bit_end
);

    // R1
    last_slot_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx == SLOT_W'(SLOTS - 1)) |-> link_out);

    // R2
    first_slot_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx == '0) |-> !link_out);

    // R3
    fall_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_out) |-> (slot_idx == '0));

    // R4
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_end |=> $stable(level_q));

    // R5
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |=> !bit_strobe);

    // R5
    strobe_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> (slot_idx == '0));

    // R7
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_en |=> ($stable(link_out) && $stable(slot_idx) && !bit_strobe));

endmodule

bind pwm_link_encoder pwm_link_encoder_chk #(.SLOTS(SLOTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_en    (slot_en),
    .link_out   (link_out),
    .bit_strobe (bit_strobe),
    .slot_idx   (slot_idx),
    .level_q    (level_q),
    .bit_end    (bit_end)
);

// File: tb/pwm_link_encoder_bench.sv
`timescale 1ns/1ps
module pwm_link_encoder_bench;

    localparam int SLOTS = 4;
    localparam int WIN   = 64;   // 16 periods x 4 slots
    // bit 3: level driven for the following bit; bits 2:0: expected high slots
    localparam logic [3:0] VEC [0:5] = '{4'b0_001, 4'b1_011, 4'b0_001,
                                         4'b0_001, 4'b1_011, 4'b1_011};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slot_en = 1'b1;
    logic ser_bit = 1'b1;
    logic link_out;
    logic bit_strobe;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_link_encoder u_pwm_link_encoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_en    (slot_en),
        .ser_bit    (ser_bit),
        .link_out   (link_out),
        .bit_strobe (bit_strobe)
    );

    task automatic chk(string req, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One full bit window; optionally toggles ser_bit to prove it is ignored.
    task automatic check_window(int hi, bit strobe_first, string tag, bit toggle);
        logic prev;
        prev = link_out;
        for (int t = 0; t < WIN; t++) begin
            chk(tag, link_out, ((t % SLOTS) + hi) >= SLOTS);
            chk("R5", bit_strobe, (t == 0) && strobe_first);
            if ((t % SLOTS) == 0 && t > 0)
                chk("R3", (prev == 1'b1) && (link_out == 1'b0), 1'b1);
            prev = link_out;
            if (toggle) ser_bit = ~ser_bit;
            step();
        end
    endtask

    initial begin
        #600000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int hi;
        @(negedge clk);
        step();
        // R8: reset state
        chk("R8", link_out, 1'b0);
        chk("R8", bit_strobe, 1'b0);
        rst_n = 1'b1;

        // Vector walk: first window is idle mark (R6), then each listed bit.
        hi = 3;
        for (int v = 0; v < 6; v++) begin
            ser_bit = VEC[v][3];
            check_window(hi, v > 0, (hi == 3) ? ((v == 0) ? "R6" : "R1") : "R2", 1'b0);
            hi = int'(VEC[v][2:0]);
        end
        ser_bit = 1'b1;
        check_window(hi, 1'b1, "R1", 1'b0);
        check_window(3, 1'b1, "R6", 1'b0);

        // R8: reset in the middle of a bit.
        step();
        step();
        rst_n = 1'b0;
        ser_bit = 1'b0;
        step();
        chk("R8", link_out, 1'b0);
        chk("R8", bit_strobe, 1'b0);
        rst_n = 1'b1;

        // R4: ser_bit toggles every cycle; first window after reset stays mark.
        check_window(3, 1'b0, "R4", 1'b1);
        chk("R5", bit_strobe, 1'b1);

        // R7: freeze with slot_en low right after reset.
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        slot_en = 1'b0;
        for (int k = 0; k < 6; k++) begin
            ser_bit = ~ser_bit;
            step();
            chk("R7", link_out, 1'b0);
            chk("R7", bit_strobe, 1'b0);
        end
        slot_en = 1'b1;
        ser_bit = 1'b1;
        step();
        chk("R7", link_out, 1'b1);   // slot 1 of a mark period
        step();
        step();
        chk("R7", link_out, 1'b1);   // slot 3
        step();
        chk("R3", link_out, 1'b0);   // slot 0 of next period

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule